// File: doc/BRIEF.md
# Unlock-Gated Two-Wire Configuration Receiver

This block takes configuration words from a slow two-wire link made of a serial clock line and a serial data line. Both wires are asynchronous to the block. They are brought into a free-running system clock domain through synchronizers, and edges are detected there. A word is only accepted after an unlock pattern: a run of at least five serial-clock rising edges with data high, then one rising edge with data low.

After unlock, each bit is sent as a pair of values. The data line carries the inverse of the bit when the serial clock falls and the bit itself when the serial clock rises. A frame is a start bit, then 21 data bits, then 3 address bits, then a stop command. The block checks the start bit, the pairing of every bit, the length of the word and the stop command. A good word gives one write strobe, with the address and data presented on that strobe.

Every frame, whether it loads or fails, drops the lock, so a new unlock is needed before the next frame. A watchdog restarts on every wire transition. If it expires, the partial word is thrown away and the lock is dropped. Any framing fault pulls an active-low error flag low. The flag stays low until the next complete unlock. While power-down is asserted, the link is ignored.

Top module: `cfg_serial_rx`

## Requirements
- R1: After reset, `err_n` is 1 and `wr_stb` is 0.
- R2: The receiver unlocks only when at least MIN_ONES (default 5) consecutive serial-clock rising edges see data high and the next rising edge sees data low. With fewer high-data edges, the frame that follows produces no write.
- R3: Each bit after unlock is valid only if the data value sampled at the serial-clock falling edge is the inverse of the value sampled at the next rising edge. The rising-edge value is the bit. If the two values are not inverses, `err_n` goes to 0 and the frame is dropped.
- R4: The first bit after unlock is the start bit and must be 0. A start bit of 1 drives `err_n` to 0 and the frame is dropped.
- R5: The start bit is followed by 21 data bits, least significant first, then 3 address bits, least significant first, then a stop command. The stop command is data high at both the falling and the rising serial-clock edge. A correct frame raises `wr_stb` with `wr_data` and `wr_addr` equal to the sent values, and `err_n` stays 1.
- R6: After the 24th bit, anything other than a stop command drives `err_n` to 0 and causes no write. This includes a correctly paired extra bit.
- R7: Once `err_n` is 0, it stays 0 through any later wire activity until an unlock sequence completes. A completed unlock sets `err_n` back to 1.
- R8: After a load or an error, the lock is dropped. A frame sent without a new unlock produces no write.
- R9: If no transition occurs on either wire for WDOG_CYCLES system-clock cycles, the lock is dropped and the partial word is discarded. `err_n` is not changed by this. A later unlocked frame loads normally.
- R10: While `pwr_down` is 1, the lock is held dropped and no write strobe is produced. After `pwr_down` returns to 0, frames are accepted again.
- R11: `wr_stb` is high for exactly one system-clock cycle per accepted frame. `wr_data` and `wr_addr` hold their values until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | Serial clock wire (asynchronous) |
| sdat_in | input | 1 | Serial data wire (asynchronous) |
| pwr_down | input | 1 | When high, serial input is ignored |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_addr | output | 3 | Target register address |
| wr_data | output | 21 | Data field to write |
| err_n | output | 1 | Active-low framing error flag |

## Verification
A wrong lock state shows up as a write strobe that should not happen, or as a missing write, at the end of the following frame. That is at most one frame time after the fault. A wrong bit counter or shift order shows up as a wrong `wr_addr` or `wr_data`, or as an error flag, at the stop command. A bad pairing or start-bit check shows on `err_n` within about three system cycles of the offending serial-clock rising edge. A watchdog that never fires shows up as a write from a frame that was split by a long idle gap.

// File: rtl/cfg_rx_pkg.sv
package cfg_rx_pkg;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_START = 2'd1,
    ST_SHIFT = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_t;

  // A bit slot is well formed when the falling-edge sample inverts the rising one.
  function automatic logic pair_ok(input logic fall_val, input logic rise_val);
    return fall_val ^ rise_val;
  endfunction

  // The load command keeps data high across both serial-clock edges.
  function automatic logic is_stop(input logic fall_val, input logic rise_val);
    return fall_val & rise_val;
  endfunction

endpackage

// File: rtl/cfg_rx_sync.sv
module cfg_rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic prev
);

  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= {(STAGES+1){RST_VAL}};
    end else begin
      pipe_q <= {pipe_q[STAGES-1:0], din};
    end
  end

  assign level = pipe_q[STAGES-1];
  assign prev  = pipe_q[STAGES];

endmodule

// File: rtl/cfg_rx_wdog.sv
module cfg_rx_wdog #(
  parameter int LIMIT = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic tout
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (kick) begin
      cnt_q <= '0;
    end else if (cnt_q != CW'(LIMIT)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // One pulse on the cycle the quiet gap reaches the limit.
  assign tout = !kick && (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/cfg_rx_unlock.sv
module cfg_rx_unlock #(
  parameter int MIN_ONES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic sclk_rise,
  input  logic sdat,
  output logic unlock,
  output logic ones_sat
);

  localparam int OW = $clog2(MIN_ONES + 1);

  logic [OW-1:0] ones_q;

  assign ones_sat = (ones_q == OW'(MIN_ONES));
  assign unlock   = !clear && sclk_rise && !sdat && ones_sat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= '0;
    end else if (clear) begin
      ones_q <= '0;
    end else if (sclk_rise) begin
      if (!sdat) begin
        ones_q <= '0;
      end else if (!ones_sat) begin
        ones_q <= ones_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cfg_rx_frame.sv
module cfg_rx_frame
  import cfg_rx_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sdat,
  input  logic              unlock,
  output logic              locked,
  output logic              frame_err,
  output logic              load,
  output logic [WORD_W-1:0] word
);

  localparam int CNT_W = $clog2(WORD_W + 1);

  rx_state_t         state_q;
  logic              comp_q;
  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              bit_ok;
  logic              last_bit;

  assign bit_ok   = pair_ok(comp_q, sdat);
  assign last_bit = (cnt_q == CNT_W'(WORD_W - 1));

  always_comb begin
    frame_err = 1'b0;
    load      = 1'b0;
    if (!abort && sclk_rise) begin
      case (state_q)
        ST_START: frame_err = !bit_ok || sdat;
        ST_SHIFT: frame_err = !bit_ok;
        ST_STOP: begin
          load      = is_stop(comp_q, sdat);
          frame_err = !is_stop(comp_q, sdat);
        end
        default: frame_err = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      comp_q  <= 1'b0;
      sh_q    <= '0;
      cnt_q   <= '0;
    end else if (abort) begin
      state_q <= ST_HUNT;
      cnt_q   <= '0;
    end else begin
      if (sclk_fall) begin
        comp_q <= sdat;
      end
      case (state_q)
        ST_HUNT: begin
          if (unlock) begin
            state_q <= ST_START;
            cnt_q   <= '0;
          end
        end
        ST_START: begin
          if (sclk_rise) begin
            state_q <= frame_err ? ST_HUNT : ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (sclk_rise) begin
            if (frame_err) begin
              state_q <= ST_HUNT;
            end else begin
              sh_q  <= {sdat, sh_q[WORD_W-1:1]};
              cnt_q <= cnt_q + 1'b1;
              if (last_bit) begin
                state_q <= ST_STOP;
              end
            end
          end
        end
        default: begin
          if (sclk_rise) begin
            state_q <= ST_HUNT;
          end
        end
      endcase
    end
  end

  assign locked = (state_q != ST_HUNT);
  assign word   = sh_q;

endmodule

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx #(
  parameter int DATA_W      = 21,
  parameter int ADDR_W      = 3,
  parameter int MIN_ONES    = 5,
  parameter int WDOG_CYCLES = 100000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_in,
  input  logic              sdat_in,
  input  logic              pwr_down,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              err_n
);

  localparam int WORD_W = DATA_W + ADDR_W;
  localparam int N_WIRE = 2;

  logic [N_WIRE-1:0] wire_raw;
  logic [N_WIRE-1:0] wire_lvl;
  logic [N_WIRE-1:0] wire_prv;

  assign wire_raw = {sdat_in, sclk_in};

  for (genvar g = 0; g < N_WIRE; g++) begin : g_sync
    cfg_rx_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
    ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (wire_raw[g]),
      .level (wire_lvl[g]),
      .prev  (wire_prv[g])
    );
  end

  logic sclk_rise;
  logic sclk_fall;
  logic sdat_s;
  logic any_edge;
  logic wdog_tout;
  logic abort;
  logic locked;
  logic unlock_evt;
  logic ones_sat;
  logic frame_err;
  logic load;
  logic [WORD_W-1:0] word;

  assign sclk_rise = wire_lvl[0] & ~wire_prv[0];
  assign sclk_fall = ~wire_lvl[0] & wire_prv[0];
  assign sdat_s    = wire_lvl[1];
  assign any_edge  = |(wire_lvl ^ wire_prv);
  assign abort     = pwr_down | wdog_tout;

  cfg_rx_wdog #(
    .LIMIT (WDOG_CYCLES)
  ) u_wdog (
    .clk   (clk),
    .rst_n (rst_n),
    .kick  (any_edge),
    .tout  (wdog_tout)
  );

  cfg_rx_unlock #(
    .MIN_ONES (MIN_ONES)
  ) u_unlock (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (abort | locked),
    .sclk_rise (sclk_rise),
    .sdat      (sdat_s),
    .unlock    (unlock_evt),
    .ones_sat  (ones_sat)
  );

  cfg_rx_frame #(
    .WORD_W (WORD_W)
  ) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (abort),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .sdat      (sdat_s),
    .unlock    (unlock_evt),
    .locked    (locked),
    .frame_err (frame_err),
    .load      (load),
    .word      (word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_n   <= 1'b1;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= load;
      if (load) begin
        wr_data <= word[DATA_W-1:0];
        wr_addr <= word[WORD_W-1:DATA_W];
      end
      if (frame_err) begin
        err_n <= 1'b0;
      end else if (unlock_evt) begin
        err_n <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cfg_serial_rx_chk.sv
module cfg_serial_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_down,
  input logic wr_stb,
  input logic err_n,
  input logic locked,
  input logic frame_err,
  input logic unlock_evt,
  input logic ones_sat,
  input logic wdog_tout
);

  assert_stb_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  assert_stb_relock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !locked);

  assert_pd_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> (!wr_stb && !locked));

  assert_err_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_n) |-> $past(frame_err));

  assert_err_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_n) |-> $past(unlock_evt));

  assert_unlock_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(ones_sat));

  assert_tout_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_tout |=> !locked);

endmodule

bind cfg_serial_rx cfg_serial_rx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_down   (pwr_down),
  .wr_stb     (wr_stb),
  .err_n      (err_n),
  .locked     (locked),
  .frame_err  (frame_err),
  .unlock_evt (unlock_evt),
  .ones_sat   (ones_sat),
  .wdog_tout  (wdog_tout)
);

// File: tb/test_cfg_serial_rx.sv
module test_cfg_serial_rx;

  localparam int HOLD = 6;
  localparam int WDOG = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk_in = 1'b1;
  logic        sdat_in = 1'b1;
  logic        pwr_down = 1'b0;
  logic        wr_stb;
  logic [2:0]  wr_addr;
  logic [20:0] wr_data;
  logic        err_n;

  int checks = 0;
  int failures = 0;
  logic [23:0] exp_q[$];
  logic        done = 1'b0;

  always #10 clk = ~clk;

  cfg_serial_rx #(.WDOG_CYCLES(WDOG)) i_cfg_serial_rx (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sdat_in(sdat_in),
    .pwr_down(pwr_down), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .err_n(err_n)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pop expected writes as strobes appear, and check one-cycle width.
  logic        prev_stb = 1'b0;
  logic [23:0] last_word = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stb) begin
        check("R11 strobe width", int'(wr_stb), 0);
        check("R11 data held", int'({wr_addr, wr_data}), int'(last_word));
      end
      if (wr_stb) begin
        if (exp_q.size() == 0) begin
          check("R8 unexpected write", 1, 0);
        end else begin
          last_word = exp_q.pop_front();
          check("R5 write word", int'({wr_addr, wr_data}), int'(last_word));
        end
      end
      prev_stb = wr_stb;
    end
  end

  task automatic wires(input logic c, input logic d);
    sclk_in = c;
    sdat_in = d;
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic unlock_seq(input int n);
    for (int i = 0; i < n; i++) begin
      wires(1'b0, 1'b1);
      wires(1'b1, 1'b1);
    end
    wires(1'b0, 1'b0);
    wires(1'b1, 1'b0);
  endtask

  task automatic send_bit(input logic b);
    wires(1'b1, ~b);
    wires(1'b0, ~b);
    wires(1'b0, b);
    wires(1'b1, b);
  endtask

  task automatic send_stop();
    wires(1'b1, 1'b1);
    wires(1'b0, 1'b1);
    wires(1'b1, 1'b1);
  endtask

  task automatic send_bits(input logic [23:0] w, input int n);
    for (int i = 0; i < n; i++) send_bit(w[i]);
  endtask

  task automatic send_word(input logic [20:0] d, input logic [2:0] a, input logic expect_wr);
    if (expect_wr) exp_q.push_back({a, d});
    send_bit(1'b0);
    send_bits({a, d}, 24);
    send_stop();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 err_n reset", int'(err_n), 1);
    check("R1 wr_stb reset", int'(wr_stb), 0);

    // R5 basic frame, minimum unlock run (R2 boundary)
    unlock_seq(5);
    send_word(21'h1A2B3C, 3'd5, 1'b1);
    check("R5 err_n after good frame", int'(err_n), 1);
    check("R5 write consumed", exp_q.size(), 0);

    // R2 long run of ones
    unlock_seq(8);
    send_word(21'h0F0F0, 3'd0, 1'b1);
    check("R2 long-run unlock write", exp_q.size(), 0);

    // R2 short run: no write
    unlock_seq(4);
    send_word(21'h0, 3'd0, 1'b0);
    check("R2 short run err_n", int'(err_n), 1);

    // R3 encoding error: falling and rising samples equal
    unlock_seq(5);
    send_bit(1'b0);
    send_bits(24'h000005, 3);
    wires(1'b1, 1'b1);
    wires(1'b0, 1'b1);
    wires(1'b1, 1'b1);
    check("R3 err_n after bad pair", int'(err_n), 0);

    // R7 stays low through stray activity, clears on unlock
    send_bit(1'b0);
    send_bit(1'b0);
    send_stop();
    check("R7 err_n held low", int'(err_n), 0);
    unlock_seq(5);
    check("R7 err_n cleared by unlock", int'(err_n), 1);
    send_word(21'h155555, 3'd2, 1'b1);
    check("R7 write after recovery", exp_q.size(), 0);

    // R4 start bit of 1
    unlock_seq(5);
    send_bit(1'b1);
    check("R4 err_n after bad start", int'(err_n), 0);

    // R6 extra bit after full word
    unlock_seq(5);
    check("R6 err_n cleared before test", int'(err_n), 1);
    send_bit(1'b0);
    send_bits(24'h3ABCDE, 24);
    send_bit(1'b1);
    check("R6 err_n after extra bit", int'(err_n), 0);

    // R6 stop with data low on the rising edge
    unlock_seq(5);
    send_bit(1'b0);
    send_bits(24'h000000, 24);
    wires(1'b1, 1'b1);
    wires(1'b0, 1'b1);
    wires(1'b1, 1'b0);
    check("R6 err_n after low stop", int'(err_n), 0);

    // R8 no relock after a load
    unlock_seq(5);
    send_word(21'h00ABC, 3'd7, 1'b1);
    send_word(21'h0, 3'd0, 1'b0);
    check("R8 no write without unlock", exp_q.size(), 0);

    // R9 watchdog discards partial word
    unlock_seq(5);
    send_bit(1'b0);
    send_bits(24'h000000, 10);
    repeat (WDOG + 40) @(negedge clk);
    send_bits(24'h000000, 14);
    send_stop();
    check("R9 err_n unchanged by timeout", int'(err_n), 1);
    unlock_seq(5);
    send_word(21'h10001, 3'd3, 1'b1);
    check("R9 write after timeout", exp_q.size(), 0);

    // R10 power-down ignores a full frame
    pwr_down = 1'b1;
    unlock_seq(5);
    send_word(21'h1FFFFF, 3'd6, 1'b0);
    check("R10 err_n during power-down", int'(err_n), 1);
    pwr_down = 1'b0;
    repeat (4) @(negedge clk);
    unlock_seq(5);
    send_word(21'h0C0FFE, 3'd1, 1'b1);

    repeat (20) @(negedge clk);
    check("R10 all expected writes seen", exp_q.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule